// File: doc/BRIEF.md
# SPI Mode-0 Master with Chip-Select Timing Guards

This block is a serial-peripheral master for devices that have strict rules on their active-low select line. A host hands it bytes one at a time over a valid/ready stream. Each byte carries three flags. A last flag closes the current operation. A fixed flag is taken from the first byte of an operation and marks the operation as fixed-length; when it is clear the operation is open-ended. A keep flag asks for the select line to stay low after the operation. The block shifts each byte out MSB first in SPI mode 0 and captures the byte that comes back at the same time.

All chip-select timing is counted in system-clock cycles. The count from CS_n falling to the first SCK edge is a parameter. So is the minimum time from the final SCK falling edge to CS_n rising, and so is the minimum CS_n high time before the next operation. A fixed-length operation that ends with the keep flag leaves CS_n low, so the next operation can start at once. An open-ended operation always ends with the full hold, deassert and idle sequence, whatever its keep flag says. The SCK half-period is a divider parameter. With a 100 MHz system clock the defaults give a 5 MHz SCK, a 60 ns hold and a 20 ns idle gap.

Top module: `spi_cs_master`

## Requirements
- R1: While reset is active and right after it, cs_n is 1, sck is 0, busy is 0, cmd_ready is 1 and rx_valid is 0.
- R2: sck is 0 whenever cs_n is 1. Each byte appears on mosi MSB first. It is stable at every rising sck edge and changes only after a falling edge.
- R3: miso is sampled on each rising sck edge, MSB first. After the eighth rising edge of a byte, rx_data holds that byte and rx_valid is 1 for exactly one clock cycle while sck is still high.
- R4: At least SETUP_CYC clock cycles pass between cs_n falling and the first rising sck edge.
- R5: cs_n rises no sooner than HOLD_CYC clock cycles after the last falling sck edge.
- R6: Once cs_n has risen, it stays high for at least IDLE_CYC clock cycles before it falls again.
- R7: An operation whose first byte has cmd_fixed=0 (open-ended) always ends with cs_n going high after its last byte, even when cmd_keep=1.
- R8: An operation whose first byte has cmd_fixed=1 (fixed-length) keeps cs_n low after its last byte if cmd_keep=1 on that byte. If cmd_keep=0, cs_n goes high.
- R9: Inside an operation, cs_n stays low between bytes. cmd_fixed on any byte other than the first is ignored.
- R10: busy is 1 from cs_n falling until the idle time has expired. cmd_ready is 0 while a byte is shifting and during the hold and idle phases. cmd_ready is 1 when the block is idle, and also when cs_n is low and the block is waiting for the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host offers a byte |
| cmd_ready | output | 1 | Block accepts the byte this cycle |
| cmd_data | input | 8 | Byte to transmit |
| cmd_last | input | 1 | Byte closes its operation |
| cmd_fixed | input | 1 | On the first byte: 1 means fixed-length, 0 means open-ended |
| cmd_keep | input | 1 | On the last byte: keep select low (honoured only for fixed-length) |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |
| busy | output | 1 | Select active, or the idle gap is still running |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the peripheral |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data from the peripheral |

## Verification
The hardest case to reach from the ports is a chain of operations that share one low period of cs_n. It needs a fixed-length operation carrying the keep flag, then a new operation whose type flag differs from the previous one, and an open-ended operation carrying a keep flag that must be overruled. The stimulus table strings these bytes together in one run, with idle host cycles between some bytes. A behavioural peripheral in the bench shifts out a known byte sequence on falling edges. After every byte, the bench checks whether the select line is still low or has gone through a full release.

// File: rtl/spi_cs_master.sv
module spi_cs_master #(
  parameter int HALF_CYC  = 10,
  parameter int SETUP_CYC = 3,
  parameter int HOLD_CYC  = 6,
  parameter int IDLE_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [7:0] cmd_data,
  input  logic       cmd_last,
  input  logic       cmd_fixed,
  input  logic       cmd_keep,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       busy,
  output logic       sck,
  output logic       mosi,
  output logic       cs_n,
  input  logic       miso
);
  localparam int HALF  = (HALF_CYC  < 1) ? 1 : HALF_CYC;
  localparam int SETUP = (SETUP_CYC < 1) ? 1 : SETUP_CYC;
  localparam int HOLD  = (HOLD_CYC  < 1) ? 1 : HOLD_CYC;
  localparam int IDLE  = (IDLE_CYC  < 1) ? 1 : IDLE_CYC;
  localparam int M1 = (HALF > SETUP) ? HALF : SETUP;
  localparam int M2 = (HOLD > IDLE) ? HOLD : IDLE;
  localparam int MX = (M1 > M2) ? M1 : M2;
  localparam int CW = $clog2(MX + 1);
  localparam logic [CW-1:0] HALF_LD  = CW'(HALF - 1);
  localparam logic [CW-1:0] SETUP_LD = CW'(SETUP - 1);
  localparam logic [CW-1:0] HOLD_LD  = CW'(HOLD - 1);
  localparam logic [CW-1:0] IDLE_LD  = CW'(IDLE - 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_SHIFT, S_WAIT, S_HOLD, S_GAP} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [2:0]    bit_idx;
  logic [7:0]    tx_sr, rx_sr;
  logic          in_op, op_fixed, last_q, keep_q;

  assign cmd_ready = (state == S_IDLE) || (state == S_WAIT);
  assign busy      = (state != S_IDLE);
  assign cs_n      = (state == S_IDLE) || (state == S_GAP);
  assign mosi      = tx_sr[7];

  wire take      = cmd_valid && cmd_ready;
  wire cnt_done  = (cnt == '0);
  wire fixed_now = in_op ? op_fixed : cmd_fixed;
  wire stay_low  = !last_q || (op_fixed && keep_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      bit_idx  <= '0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      in_op    <= 1'b0;
      op_fixed <= 1'b0;
      last_q   <= 1'b0;
      keep_q   <= 1'b0;
      sck      <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (take) begin
        tx_sr    <= cmd_data;
        last_q   <= cmd_last;
        keep_q   <= cmd_keep;
        op_fixed <= fixed_now;
        in_op    <= !cmd_last;
        bit_idx  <= '0;
      end
      case (state)
        S_IDLE: if (take) begin
          state <= S_SETUP;
          cnt   <= SETUP_LD;
        end
        S_SETUP: if (cnt_done) begin
          state <= S_SHIFT;
          cnt   <= HALF_LD;
        end else cnt <= cnt - CW'(1);
        S_WAIT: if (take) begin
          state <= S_SHIFT;
          cnt   <= HALF_LD;
        end
        S_SHIFT: if (!cnt_done) cnt <= cnt - CW'(1);
        else begin
          cnt <= HALF_LD;
          if (!sck) begin
            sck   <= 1'b1;
            rx_sr <= {rx_sr[6:0], miso};
            if (bit_idx == 3'd7) begin
              rx_valid <= 1'b1;
              rx_data  <= {rx_sr[6:0], miso};
            end
          end else begin
            sck <= 1'b0;
            if (bit_idx != 3'd7) begin
              bit_idx <= bit_idx + 3'd1;
              tx_sr   <= {tx_sr[6:0], 1'b0};
            end else if (stay_low) begin
              state <= S_WAIT;
            end else begin
              state <= S_HOLD;
              cnt   <= HOLD_LD;
            end
          end
        end
        S_HOLD: if (cnt_done) begin
          state <= S_GAP;
          cnt   <= IDLE_LD;
        end else cnt <= cnt - CW'(1);
        S_GAP: if (cnt_done) state <= S_IDLE;
        else cnt <= cnt - CW'(1);
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cs_master_chk.sv
module spi_cs_master_chk #(
  parameter int HOLD_CYC = 6,
  parameter int IDLE_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic busy,
  input logic cmd_ready,
  input logic rx_valid
);
  logic [15:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '1;
    end else begin
      lo_cnt <= sck ? 16'd0 : ((lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 16'd1);
      hi_cnt <= !cs_n ? 16'd0 : ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1);
    end
  end

  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  assert_rx_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_rx_in_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (!cs_n && sck));
  assert_cs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (lo_cnt >= 16'(HOLD_CYC)));
  assert_cs_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hi_cnt >= 16'(IDLE_CYC)));
  assert_busy_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && cs_n) |-> !busy);
  assert_ready_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !sck);
endmodule

bind spi_cs_master spi_cs_master_chk #(.HOLD_CYC(HOLD_CYC), .IDLE_CYC(IDLE_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .busy(busy),
  .cmd_ready(cmd_ready), .rx_valid(rx_valid)
);

// File: tb/spi_cs_master_tb.sv
module spi_cs_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_CYC = 10, SETUP_CYC = 3, HOLD_CYC = 6, IDLE_CYC = 2;
  localparam int NV = 12;
  // {data, last, fixed, keep}
  localparam logic [10:0] VEC [0:NV-1] = '{
    {8'hA5, 3'b000}, {8'h3C, 3'b010}, {8'hF0, 3'b101},
    {8'h81, 3'b111},
    {8'h42, 3'b010}, {8'h7E, 3'b111},
    {8'h00, 3'b000}, {8'hFF, 3'b100},
    {8'h5A, 3'b110},
    {8'hC3, 3'b010}, {8'h96, 3'b101},
    {8'hE7, 3'b100}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_last = 1'b0, cmd_fixed = 1'b0, cmd_keep = 1'b0;
  logic [7:0] cmd_data = '0;
  logic cmd_ready, rx_valid, busy, sck, mosi, cs_n;
  logic [7:0] rx_data;
  logic miso = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cs_master #(.HALF_CYC(HALF_CYC), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC),
                  .IDLE_CYC(IDLE_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .cmd_last(cmd_last), .cmd_fixed(cmd_fixed), .cmd_keep(cmd_keep),
    .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy), .sck(sck), .mosi(mosi),
    .cs_n(cs_n), .miso(miso));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] txb(input int n);
    return 8'h3C ^ 8'(n * 37);
  endfunction

  // behavioural peripheral: drives on falling sck, captures on rising sck
  int s_num = 0, s_bit = 0;
  logic [7:0] s_rx = '0, s_cur;
  logic [7:0] s_got [0:NV-1];
  always @(negedge cs_n) begin
    s_bit = 0; s_cur = txb(s_num); miso = s_cur[7];
  end
  always @(posedge cs_n) miso = 1'b0;
  always @(posedge sck) s_rx = {s_rx[6:0], mosi};
  always @(negedge sck) if (!cs_n) begin
    s_bit++;
    if (s_bit == 8) begin
      if (s_num < NV) s_got[s_num] = s_rx;
      s_num++; s_bit = 0;
    end
    s_cur = txb(s_num); miso = s_cur[7 - s_bit];
  end

  // receive log and timing monitor, sampled away from the active edge
  logic [7:0] rx_log [0:NV-1];
  int rx_n = 0, rx_run = 0, rx_dbl = 0, rx_nosck = 0;
  int rises = 0, bad_idle = 0, lo_run = 0, hi_run = 1000, su_run = 0;
  int min_hold = 1000, min_hi = 1000, min_su = 1000;
  bit prev_cs = 1, in_su = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_cs = 1; hi_run = 1000; lo_run = 0; in_su = 0; rx_run = 0;
    end else begin
      if (cs_n && sck) bad_idle++;
      if (!prev_cs && cs_n) begin rises++; if (lo_run < min_hold) min_hold = lo_run; end
      if (prev_cs && !cs_n) begin if (hi_run < min_hi) min_hi = hi_run; su_run = 0; in_su = 1; end
      hi_run = cs_n ? hi_run + 1 : 0;
      lo_run = sck ? 0 : lo_run + 1;
      if (in_su) begin
        if (sck) begin if (su_run < min_su) min_su = su_run; in_su = 0; end
        else su_run++;
      end
      if (rx_valid) begin
        if (rx_n < NV) rx_log[rx_n] = rx_data;
        rx_n++;
        if (!sck) rx_nosck++;
        rx_run++;
        if (rx_run > 1) rx_dbl++;
      end else rx_run = 0;
      prev_cs = cs_n;
    end
  end

  task automatic send(input logic [7:0] d, input bit l, input bit f, input bit k);
    @(negedge clk);
    cmd_valid = 1; cmd_data = d; cmd_last = l; cmd_fixed = f; cmd_keep = k;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit in_op_b = 0, cur_fixed = 0;
    repeat (3) @(negedge clk);
    check(cs_n && !sck && !busy && cmd_ready && !rx_valid, "R1 in reset",
          {cs_n, sck, busy, cmd_ready, rx_valid}, 5'b10010);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(cs_n && !sck && !busy && cmd_ready && !rx_valid, "R1 after reset",
          {cs_n, sck, busy, cmd_ready, rx_valid}, 5'b10010);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] d; bit l, f, k, drop;
      {d, l, f, k} = VEC[i];
      if (!in_op_b) cur_fixed = f;
      in_op_b = !l;
      drop = l && !(cur_fixed && k);
      repeat (i % 3) @(negedge clk);
      send(d, l, f, k);
      check(!cmd_ready && busy && !cs_n, "R10 busy while shifting",
            {cmd_ready, busy, cs_n}, 3'b010);
      while (!cmd_ready) @(negedge clk);
      check(s_got[i] == d, "R2 mosi byte", s_got[i], d);
      check(rx_n == i + 1 && rx_log[i] == txb(i), "R3 rx byte", rx_log[i], txb(i));
      if (drop)
        check(cs_n && !busy, cur_fixed ? "R8 fixed no-keep release" : "R7 open release",
              {cs_n, busy}, 2'b10);
      else
        check(!cs_n && busy, !l ? "R9 low between bytes" : "R8 fixed keep chain",
              {cs_n, busy}, 2'b01);
    end
    repeat (20) @(negedge clk);
    check(rises == 4, "R7 R8 count of cs_n releases", rises, 4);
    check(min_hold >= HOLD_CYC, "R5 hold after last sck", min_hold, HOLD_CYC);
    check(min_hi >= IDLE_CYC, "R6 cs_n high gap", min_hi, IDLE_CYC);
    check(min_su >= SETUP_CYC, "R4 setup before sck", min_su, SETUP_CYC);
    check(bad_idle == 0, "R2 sck idle low", bad_idle, 0);
    check(rx_dbl == 0 && rx_nosck == 0, "R3 one-cycle strobe in high phase",
          rx_dbl + rx_nosck, 0);
    check(rx_n == NV, "R3 strobe count", rx_n, NV);

    // reset in the middle of a byte
    send(8'h55, 1, 0, 0);
    repeat (30) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check(cs_n && !sck && !busy && cmd_ready && !rx_valid, "R1 mid-byte reset",
          {cs_n, sck, busy, cmd_ready, rx_valid}, 5'b10010);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(cs_n && !sck && !busy && cmd_ready, "R1 after mid-byte reset",
          {cs_n, sck, busy, cmd_ready}, 4'b1001);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule